// File: doc/BRIEF.md
# Low-Power Watchdog Timer

This block is a watchdog counter that has a five-bit mode register. Two bits of the register pick one of four timeout lengths. Two more bits decide whether the count keeps going while the chip is in HALT and while it is in STOP. The last bit picks which tick drives the counter. One choice is a free-running internal RC tick, which the design counts in units of `RC_TICKS_PER_UNIT` ticks, where one unit stands for 5 ms. The other choice is the crystal-clock tick. Both ticks arrive as one-cycle enables on the single system clock, so the design never switches between clocks.

Software starts the watchdog with a refresh strobe, and each later strobe restarts the timeout. A strap input can make the watchdog active as soon as reset is released. When the count expires in run or HALT, the block pulses a reset request. When it expires in STOP, the block pulses a wake request instead, and the power controller treats that request like any other STOP recovery source. The oscillators, the reset-delay generator and the rest of the power controller are outside this block.

Top module: `watchdog_lp`

## Requirements
- R1: After reset the mode register holds 5'b01101. The fields are mode_wdata[1:0] = period select, [2] = run in HALT, [3] = run in STOP and [4] = tick source, where 0 is RC and 1 is crystal. So the reset state is period code 01, both run bits set and the RC source. A write on `mode_we` loads `mode_wdata` into the register.
- R2: With the crystal source, period codes 00, 01, 10 and 11 expire on the 256th, 512th, 1024th and 4096th counted crystal tick.
- R3: With the RC source, period codes 00, 01, 10 and 11 expire after 1, 2, 4 and 16 units of `RC_TICKS_PER_UNIT` RC ticks.
- R4: With the strap low, every reset disarms the watchdog. No request is raised, however many ticks arrive, until `kick` is asserted.
- R5: A `kick` arms the watchdog and clears the count. The next expiry comes one full period after the last kick.
- R6: With the strap high, the watchdog counts from reset release without any kick.
- R7: In HALT the count advances only when the run-in-HALT bit is 1. When that bit is 0 the count is held, and counting resumes from the held value when HALT ends.
- R8: In STOP the count advances only when the run-in-STOP bit is 1 and the RC source is selected. An expiry in STOP raises `wake_req` and not `rst_req`.
- R9: An expiry gives a one-cycle pulse in the cycle after the clock edge that takes the final tick. The count then restarts from zero and the watchdog stays armed, so it expires again after another full period.
- R10: A mode-register write clears the count.
- R11: Ticks on the source that is not selected have no effect on the count.
- R12: `rst_req` and `wake_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| strap_always_on | input | 1 | Static option: watchdog active from reset release |
| kick | input | 1 | Refresh/arm strobe |
| halt_i | input | 1 | Chip is in HALT |
| stop_i | input | 1 | Chip is in STOP |
| rc_tick | input | 1 | One-cycle tick from the internal RC oscillator |
| xt_tick | input | 1 | One-cycle tick from the crystal clock |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 5 | Mode register write data |
| rst_req | output | 1 | One-cycle reset request on expiry in run or HALT |
| wake_req | output | 1 | One-cycle wake request on expiry in STOP |

## Verification
The bench builds the block with `RC_TICKS_PER_UNIT` = 3 and the prescaled RC variant. This makes every RC period short, from 3 to 48 ticks. Every RC code and every crystal code, including the 4096-tick period, can then be measured tick by tick. The small unit also forces the prescaler to wrap many times within each period. That exposes phase errors after a kick, after a mode write and across a HALT freeze.

// File: rtl/wdt_lp_pkg.sv
package wdt_lp_pkg;

   typedef struct packed {
      logic       src_xtal;    // bit 4
      logic       stop_run;    // bit 3
      logic       halt_run;    // bit 2
      logic [1:0] period_sel;  // bits 1:0
   } wdt_mode_t;

   localparam int MODE_W = $bits(wdt_mode_t);

   localparam wdt_mode_t MODE_AT_RESET = '{
      src_xtal:   1'b0,
      stop_run:   1'b1,
      halt_run:   1'b1,
      period_sel: 2'b01
   };

   localparam int XTAL_PERIOD_MAX = 4096;
   localparam int RC_UNITS_MAX    = 16;

   function automatic int xtal_period(input logic [1:0] s);
      case (s)
         2'b00:   return 256;
         2'b01:   return 512;
         2'b10:   return 1024;
         default: return XTAL_PERIOD_MAX;
      endcase
   endfunction

   function automatic int rc_units(input logic [1:0] s);
      case (s)
         2'b00:   return 1;
         2'b01:   return 2;
         2'b10:   return 4;
         default: return RC_UNITS_MAX;
      endcase
   endfunction

endpackage

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg
   import wdt_lp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_data,
   output wdt_mode_t         mode
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mode <= MODE_AT_RESET;
      else if (wr_en) mode <= wdt_mode_t'(wr_data);
   end

   // R1
   write_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mode == $past(wr_data)));

endmodule

// File: rtl/wdt_tick_gate.sv
module wdt_tick_gate
   import wdt_lp_pkg::*;
(
   input  wdt_mode_t mode,
   input  logic      active,
   input  logic      rc_tick,
   input  logic      xt_tick,
   input  logic      halt_i,
   input  logic      stop_i,
   output logic      cnt_en
);

   logic raw_tick;
   logic allowed;

   always_comb begin
      raw_tick = mode.src_xtal ? xt_tick : rc_tick;
      if (stop_i)      allowed = mode.stop_run && !mode.src_xtal;
      else if (halt_i) allowed = mode.halt_run;
      else             allowed = 1'b1;
      cnt_en = active && raw_tick && allowed;
   end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
   import wdt_lp_pkg::*;
#(
   parameter int RC_TICKS_PER_UNIT = 160,
   parameter bit USE_RC_PRESCALER  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       step,
   input  logic       src_xtal,
   input  logic [1:0] sel,
   output logic       wrap
);

   localparam int DIRECT_MAX = (RC_UNITS_MAX * RC_TICKS_PER_UNIT > XTAL_PERIOD_MAX)
                               ? RC_UNITS_MAX * RC_TICKS_PER_UNIT : XTAL_PERIOD_MAX;
   localparam int CW = $clog2(DIRECT_MAX);
   localparam int PW = (RC_TICKS_PER_UNIT > 2) ? $clog2(RC_TICKS_PER_UNIT) : 1;

   if (RC_TICKS_PER_UNIT < 2) begin : g_bad_unit
      $error("wdt_counter: RC_TICKS_PER_UNIT must be at least 2");
   end

   if (USE_RC_PRESCALER) begin : g_prescaled
      logic [PW-1:0] pre;
      logic [CW-1:0] cnt;
      logic [CW-1:0] lim_m1;
      logic          pre_wrap;
      logic          unit_step;

      always_comb begin
         pre_wrap  = step && !src_xtal && (pre == PW'(RC_TICKS_PER_UNIT - 1));
         unit_step = src_xtal ? step : pre_wrap;
         lim_m1    = src_xtal ? CW'(xtal_period(sel) - 1) : CW'(rc_units(sel) - 1);
         wrap      = unit_step && !clear && (cnt == lim_m1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  pre <= '0;
         else if (clear || pre_wrap)  pre <= '0;
         else if (step && !src_xtal)  pre <= pre + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         cnt <= '0;
         else if (clear)     cnt <= '0;
         else if (unit_step) cnt <= wrap ? '0 : cnt + 1'b1;
      end

      // R3
      prescale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         int'(pre) < RC_TICKS_PER_UNIT);

      // R9
      restart_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wrap |=> (cnt == '0));
   end else begin : g_direct
      logic [CW-1:0] cnt;
      logic [CW-1:0] lim_m1;

      always_comb begin
         lim_m1 = src_xtal ? CW'(xtal_period(sel) - 1)
                           : CW'(rc_units(sel) * RC_TICKS_PER_UNIT - 1);
         wrap   = step && !clear && (cnt == lim_m1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt <= '0;
         else if (clear) cnt <= '0;
         else if (step)  cnt <= wrap ? '0 : cnt + 1'b1;
      end

      // R9
      restart_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wrap |=> (cnt == '0));
   end

endmodule

// File: rtl/watchdog_lp.sv
module watchdog_lp
   import wdt_lp_pkg::*;
#(
   parameter int RC_TICKS_PER_UNIT = 160,
   parameter bit USE_RC_PRESCALER  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_always_on,
   input  logic              kick,
   input  logic              halt_i,
   input  logic              stop_i,
   input  logic              rc_tick,
   input  logic              xt_tick,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   output logic              rst_req,
   output logic              wake_req
);

   if (RC_TICKS_PER_UNIT < 2) begin : g_bad_unit
      $error("watchdog_lp: RC_TICKS_PER_UNIT must be at least 2");
   end

   wdt_mode_t mode;
   logic      armed;
   logic      active;
   logic      cnt_en;
   logic      clear;
   logic      wrap;

   wdt_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mode_we),
      .wr_data (mode_wdata),
      .mode    (mode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    armed <= 1'b0;
      else if (kick) armed <= 1'b1;
   end

   always_comb begin
      active = armed || strap_always_on;
      clear  = kick || mode_we || !active;
   end

   wdt_tick_gate u_gate (
      .mode    (mode),
      .active  (active),
      .rc_tick (rc_tick),
      .xt_tick (xt_tick),
      .halt_i  (halt_i),
      .stop_i  (stop_i),
      .cnt_en  (cnt_en)
   );

   wdt_counter #(
      .RC_TICKS_PER_UNIT (RC_TICKS_PER_UNIT),
      .USE_RC_PRESCALER  (USE_RC_PRESCALER)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .step     (cnt_en),
      .src_xtal (mode.src_xtal),
      .sel      (mode.period_sel),
      .wrap     (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req  <= 1'b0;
         wake_req <= 1'b0;
      end else begin
         rst_req  <= wrap && !stop_i;
         wake_req <= wrap && stop_i;
      end
   end

   // R12
   outputs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req && wake_req));

   // R8
   wake_only_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> $past(stop_i));

   // R9
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || wake_req) |=> !(rst_req || wake_req));

   // R4
   idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !strap_always_on) |=> !(rst_req || wake_req));

endmodule

// File: tb/watchdog_lp_test.sv
`timescale 1ns/1ps
module watchdog_lp_test;

   localparam int UNIT = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap = 1'b0;
   logic       kick = 1'b0;
   logic       halt_i = 1'b0;
   logic       stop_i = 1'b0;
   logic       rc_tick = 1'b0;
   logic       xt_tick = 1'b0;
   logic       mode_we = 1'b0;
   logic [4:0] mode_wdata = 5'b0;
   logic       rst_req;
   logic       wake_req;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   watchdog_lp #(.RC_TICKS_PER_UNIT(UNIT), .USE_RC_PRESCALER(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .strap_always_on(strap), .kick(kick),
      .halt_i(halt_i), .stop_i(stop_i), .rc_tick(rc_tick), .xt_tick(xt_tick),
      .mode_we(mode_we), .mode_wdata(mode_wdata),
      .rst_req(rst_req), .wake_req(wake_req)
   );

   typedef struct packed {
      logic        do_wr;
      logic [4:0]  mode;
      logic        halt;
      logic        stop;
      logic [15:0] ticks;
      logic        wake;
   } vec_t;

   // mode bits: [4] src (1 = crystal), [3] run in STOP, [2] run in HALT, [1:0] period
   localparam vec_t VECS [0:9] = '{
      '{1'b0, 5'b01101, 1'b0, 1'b0, 16'd6,    1'b0},  // R1 R3 reset mode, RC code 01
      '{1'b1, 5'b11100, 1'b0, 1'b0, 16'd256,  1'b0},  // R2 crystal 00
      '{1'b1, 5'b11101, 1'b0, 1'b0, 16'd512,  1'b0},  // R2 crystal 01
      '{1'b1, 5'b11110, 1'b0, 1'b0, 16'd1024, 1'b0},  // R2 crystal 10
      '{1'b1, 5'b11111, 1'b0, 1'b0, 16'd4096, 1'b0},  // R2 crystal 11
      '{1'b1, 5'b01100, 1'b0, 1'b0, 16'd3,    1'b0},  // R3 RC 00
      '{1'b1, 5'b01110, 1'b0, 1'b0, 16'd12,   1'b0},  // R3 RC 10
      '{1'b1, 5'b01111, 1'b0, 1'b0, 16'd48,   1'b0},  // R3 RC 11
      '{1'b0, 5'b01101, 1'b1, 1'b0, 16'd6,    1'b0},  // R7 counting in HALT
      '{1'b0, 5'b01101, 1'b0, 1'b1, 16'd6,    1'b1}   // R8 R12 wake in STOP
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick_clk();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; kick = 1'b0; halt_i = 1'b0; stop_i = 1'b0;
      rc_tick = 1'b0; xt_tick = 1'b0; mode_we = 1'b0;
      repeat (3) tick_clk();
      rst_n = 1'b1;
      tick_clk();
   endtask

   task automatic do_kick();
      kick = 1'b1;
      tick_clk();
      kick = 1'b0;
   endtask

   task automatic do_write(input logic [4:0] m);
      mode_we = 1'b1; mode_wdata = m;
      tick_clk();
      mode_we = 1'b0;
   endtask

   task automatic run_ticks(input bit xt, input int n, output int first_at,
                            output int last_at, output int n_rst, output int n_wake,
                            output int n_wide);
      first_at = 0; last_at = 0; n_rst = 0; n_wake = 0; n_wide = 0;
      for (int i = 1; i <= n; i++) begin
         if (xt) xt_tick = 1'b1; else rc_tick = 1'b1;
         tick_clk();
         xt_tick = 1'b0; rc_tick = 1'b0;
         if (rst_req || wake_req) begin
            if (first_at == 0) first_at = i;
            last_at = i;
         end
         n_rst  += int'(rst_req);
         n_wake += int'(wake_req);
         tick_clk();
         if (rst_req || wake_req) n_wide++;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles >= 150000 && !done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int f, l, nr, nw, nx;
      do_reset();
      // reset state: both requests low (R4)
      check(rst_req == 1'b0 && wake_req == 1'b0, "R4 reset outputs", int'(rst_req) + int'(wake_req), 0);

      for (int v = 0; v < 10; v++) begin
         do_reset();
         if (VECS[v].do_wr) do_write(VECS[v].mode);
         halt_i = VECS[v].halt; stop_i = VECS[v].stop;
         do_kick();
         run_ticks(VECS[v].mode[4], int'(VECS[v].ticks), f, l, nr, nw, nx);
         check(f == int'(VECS[v].ticks), "R1/R2/R3 period", f, int'(VECS[v].ticks));
         check(nr == (VECS[v].wake ? 0 : 1), "R8 reset count", nr, VECS[v].wake ? 0 : 1);
         check(nw == (VECS[v].wake ? 1 : 0), "R8 wake count", nw, VECS[v].wake ? 1 : 0);
         check(nx == 0, "R9 pulse width", nx, 0);
         halt_i = 1'b0; stop_i = 1'b0;
      end

      // R4: disarmed after reset without kick
      do_reset();
      run_ticks(1'b0, 100, f, l, nr, nw, nx);
      check(nr + nw == 0, "R4 no kick", nr + nw, 0);

      // R6: strap active from reset release
      strap = 1'b1;
      do_reset();
      run_ticks(1'b0, 6, f, l, nr, nw, nx);
      check(f == 6 && nr == 1, "R6 strap period", f, 6);
      strap = 1'b0;

      // R5: kick restarts timeout
      do_reset(); do_kick();
      run_ticks(1'b0, 4, f, l, nr, nw, nx);
      do_kick();
      run_ticks(1'b0, 6, f, l, nr, nw, nx);
      check(f == 6 && nr == 1, "R5 restart by kick", f, 6);

      // R9: stays armed, second expiry one period later
      do_reset(); do_kick();
      run_ticks(1'b0, 12, f, l, nr, nw, nx);
      check(nr == 2, "R9 repeat count", nr, 2);
      check(l == 12, "R9 second expiry", l, 12);
      check(nw == 0, "R12 no wake in run", nw, 0);

      // R7: frozen in HALT when run-in-HALT is 0
      do_reset(); do_write(5'b01001); do_kick();
      run_ticks(1'b0, 2, f, l, nr, nw, nx);
      halt_i = 1'b1;
      run_ticks(1'b0, 20, f, l, nr, nw, nx);
      check(nr + nw == 0, "R7 halt frozen", nr + nw, 0);
      halt_i = 1'b0;
      run_ticks(1'b0, 4, f, l, nr, nw, nx);
      check(f == 4, "R7 resume held count", f, 4);

      // R8: crystal source does not count in STOP
      do_reset(); do_write(5'b11101); do_kick();
      stop_i = 1'b1;
      run_ticks(1'b1, 600, f, l, nr, nw, nx);
      check(nr + nw == 0, "R8 crystal stop", nr + nw, 0);
      stop_i = 1'b0;

      // R8: run-in-STOP cleared freezes count
      do_reset(); do_write(5'b00101); do_kick();
      stop_i = 1'b1;
      run_ticks(1'b0, 20, f, l, nr, nw, nx);
      check(nr + nw == 0, "R8 stop disabled", nr + nw, 0);
      stop_i = 1'b0;
      run_ticks(1'b0, 6, f, l, nr, nw, nx);
      check(f == 6 && nr == 1, "R8 after stop", f, 6);

      // R10: mode write clears count
      do_reset(); do_kick();
      run_ticks(1'b0, 4, f, l, nr, nw, nx);
      do_write(5'b01101);
      run_ticks(1'b0, 6, f, l, nr, nw, nx);
      check(f == 6, "R10 write clears", f, 6);

      // R11: unselected crystal ticks ignored
      do_reset(); do_kick();
      run_ticks(1'b1, 50, f, l, nr, nw, nx);
      check(nr + nw == 0, "R11 ignored ticks", nr + nw, 0);
      run_ticks(1'b0, 6, f, l, nr, nw, nx);
      check(f == 6, "R11 count untouched", f, 6);

      // R4: reset disarms an armed watchdog
      do_reset(); do_kick();
      run_ticks(1'b0, 3, f, l, nr, nw, nx);
      do_reset();
      run_ticks(1'b0, 20, f, l, nr, nw, nx);
      check(nr + nw == 0, "R4 reset disarms", nr + nw, 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule